// File: doc/BRIEF.md
# Two-Phase Serial-Flash Bootstrap Target

This block sits behind a byte-level SPI target and makes the chip look like a serial NOR flash to an external programmer, so that a firmware image can be loaded into on-chip flash. Each byte the host clocks in is presented as a strobed byte on the receive side. For every byte slot the block supplies the byte that the host reads back in the next slot. Chip-select frames a command: the first byte of a frame is the opcode, and the bytes after it are address, dummy or data bytes.

The session runs in two phases. Right after reset only erase commands are acted on. A programmer therefore has to wipe the flash before it can write anything. The first erase that completes opens the second phase, in which page program and erases are passed to a flash request port as one request per command. A programmer can always poll the status byte, read the JEDEC-style identity and read the discoverable-parameter table. Reading flash contents back is never served. A reset opcode ends the session with a chip reset request. A program or erase aimed past the end of the flash ends it with a shutdown.

Top module: `spi_boot_ctrl`

## Requirements
- R1: After reset the transmit byte is 0xff, no flash request is pending, reset_req and shutdown are low, the status byte reads 0x00 and the controller is in the first phase.
- R2: Opcode 0x05 returns the status byte in the next slot and again in every further slot of the frame. Status bit 1 is the write-enable latch (WEL) and bit 0 is the busy flag (a flash request is pending). All other bits are 0.
- R3: Opcode 0x06 sets WEL and opcode 0x04 clears it, so status then reads 0x02 or 0x00.
- R4: Opcode 0x9f returns ID_CONT (default 12) bytes of 0x7f, then the manufacturer byte (default 0xef), then the density byte (default 0x14), and 0xff in every later slot.
- R5: Opcode 0x5a takes a 3-byte address (most significant byte first) and one dummy byte. Each later slot returns the parameter-table byte at the address, and the address increments per slot. Bytes 0..3 are 0x53 0x46 0x44 0x50, byte 0x11 is 0x20, bytes 0x14..0x17 hold FLASH_BYTES*8-1 least significant byte first, and bytes beyond the 52-byte table read 0xff.
- R6: Opcode 0x03 and any opcode not listed here are ignored in both phases: the transmit byte stays 0xff for every slot of the frame. While chip-select is released the transmit byte is 0xff.
- R7: In the first phase, opcode 0x02 (page program) is ignored even with WEL set. It issues no request and leaves WEL unchanged.
- R8: With WEL set, 0x20 (sector erase, plus a 3-byte address) or 0xc7 (chip erase, no address) raises fl_req in the cycle after chip-select release, with fl_op 2 or 3 and, for sector erase, fl_addr. The request holds until fl_done. Completion clears WEL and moves the controller to the second phase.
- R9: In the second phase, with WEL set, 0x02 followed by a 3-byte address and at least one data byte raises fl_req with fl_op 1 after release. The first data byte goes to fl_data bits 7:0, the next to 15:8, and so on. Slots that were not sent read 0xff, and bytes beyond PROG_BYTES are dropped.
- R10: Program and erase commands sent while WEL is clear raise no request.
- R11: Opcode 0x99 raises reset_req in the next cycle, and reset_req stays high until reset. From then on every opcode, status included, is ignored and the transmit byte is 0xff.
- R12: An accepted program or sector erase whose address is FLASH_BYTES or above raises shutdown, which stays high, in the cycle after release, and issues no request. The controller then ignores every opcode. Address FLASH_BYTES-1 is accepted.
- R13: Releasing chip-select before a command's address (or, for a program, its first data byte) is complete aborts the command with no request. WEL keeps its value.
- R14: While a request is pending, only 0x05 and 0x99 are acted on. Status then shows bit 0 set, and every other opcode returns 0xff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip-select asserted (active high); a frame lasts while it is high |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte the host reads in the next slot |
| fl_req | output | 1 | Flash request pending |
| fl_op | output | 2 | Request kind: 1 program, 2 sector erase, 3 chip erase |
| fl_addr | output | 24 | Request byte address |
| fl_data | output | 32 | Program data, first byte in the low bits |
| fl_done | input | 1 | Flash finished the pending request |
| reset_req | output | 1 | Session ended by reset opcode; chip reset wanted |
| shutdown | output | 1 | Session ended by an out-of-range address |

## Verification
The transmit byte for a slot is registered on the same edge that takes the received byte's strobe, so it is due one cycle after the strobe. reset_req also follows the opcode strobe by one cycle. A request, or a shutdown, follows the first edge that sees chip-select low, and WEL and the phase change on the edge that sees fl_done while a request is pending. The bench drives every input on the falling edge and reads outputs on the next falling edge, so each comparison lands exactly one register stage after its stimulus. It also checks a few cycles later that commands which should issue nothing still leave fl_req low.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  localparam logic [7:0] OPC_STATUS = 8'h05;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_WRDI   = 8'h04;
  localparam logic [7:0] OPC_IDENT  = 8'h9f;
  localparam logic [7:0] OPC_PTAB   = 8'h5a;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_SECT   = 8'h20;
  localparam logic [7:0] OPC_CHIP   = 8'hc7;
  localparam logic [7:0] OPC_RESET  = 8'h99;

  typedef enum logic [1:0] {
    FOP_NONE = 2'd0,
    FOP_PROG = 2'd1,
    FOP_SECT = 2'd2,
    FOP_CHIP = 2'd3
  } fop_e;

  typedef enum logic [2:0] {
    C_OPC, C_STAT, C_IDENT, C_PTAB, C_IGN, C_PROG, C_SECT, C_CHIP
  } cmd_e;

  localparam int PTAB_LEN = 52;

  // Parameter table: header, one parameter header, then the basic table.
  function automatic logic [7:0] ptab_byte(input logic [7:0] idx,
                                           input logic [23:0] dens);
    logic [7:0] b;
    b = 8'hff;
    case (idx)
      8'd0:  b = 8'h53;
      8'd1:  b = 8'h46;
      8'd2:  b = 8'h44;
      8'd3:  b = 8'h50;
      8'd4:  b = 8'h06;
      8'd5:  b = 8'h01;
      8'd6:  b = 8'h00;
      8'd8:  b = 8'h00;
      8'd9:  b = 8'h06;
      8'd10: b = 8'h01;
      8'd11: b = 8'h09;
      8'd12: b = 8'h10;
      8'd13: b = 8'h00;
      8'd14: b = 8'h00;
      8'd16: b = 8'he5;
      8'd17: b = 8'h20;
      8'd20: b = dens[7:0];
      8'd21: b = dens[15:8];
      8'd22: b = dens[23:16];
      8'd23: b = 8'h00;
      default: b = 8'hff;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/boot_resp_table.sv
module boot_resp_table
  import spi_boot_pkg::*;
#(
  parameter int          IDX_W       = 24,
  parameter int          ID_CONT     = 12,
  parameter logic [7:0]  ID_MFR      = 8'hef,
  parameter logic [7:0]  ID_DENS     = 8'h14,
  parameter int          FLASH_BYTES = 1 << 20
) (
  input  logic             use_ptab,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       resp
);
  localparam logic [23:0]      DENS_BITS = 24'(FLASH_BYTES * 8 - 1);
  localparam logic [IDX_W-1:0] CONT_L    = IDX_W'(ID_CONT);
  localparam logic [IDX_W-1:0] PLEN_L    = IDX_W'(PTAB_LEN);

  always_comb begin
    resp = 8'hff;
    if (use_ptab) begin
      if (idx < PLEN_L) resp = ptab_byte(idx[7:0], DENS_BITS);
    end else if (idx < CONT_L) begin
      resp = 8'h7f;
    end else if (idx == CONT_L) begin
      resp = ID_MFR;
    end else if (idx == CONT_L + IDX_W'(1)) begin
      resp = ID_DENS;
    end
  end
endmodule

// File: rtl/boot_addr_check.sv
module boot_addr_check #(
  parameter int ADDR_W      = 24,
  parameter int FLASH_BYTES = 1 << 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range
);
  generate
    if (64'(FLASH_BYTES) >= (64'd1 << ADDR_W)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_cmp
      localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(FLASH_BYTES);
      assign in_range = {1'b0, addr} < LIMIT;
    end
  endgenerate
endmodule

// File: rtl/boot_flash_req.sv
module boot_flash_req
  import spi_boot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  fop_e              start_op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              fl_done,
  output logic              fl_req,
  output fop_e              fl_op,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_data,
  output logic              fin,
  output logic              fin_erase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fl_req  <= 1'b0;
      fl_op   <= FOP_NONE;
      fl_addr <= '0;
      fl_data <= '0;
    end else if (fl_req && fl_done) begin
      fl_req <= 1'b0;
      fl_op  <= FOP_NONE;
    end else if (start && !fl_req) begin
      fl_req  <= 1'b1;
      fl_op   <= start_op;
      fl_addr <= start_addr;
      fl_data <= start_data;
    end
  end

  assign fin       = fl_req && fl_done;
  assign fin_erase = fin && (fl_op == FOP_SECT || fl_op == FOP_CHIP);

  // R8: a pending request keeps its contents until the flash reports done
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    fl_req && !fl_done |=> fl_req && $stable(fl_addr) && $stable(fl_op)
                           && $stable(fl_data));
endmodule

// File: rtl/spi_boot_ctrl.sv
module spi_boot_ctrl
  import spi_boot_pkg::*;
#(
  parameter int         FLASH_BYTES = 1 << 20,
  parameter int         ADDR_BYTES  = 3,
  parameter int         PROG_BYTES  = 4,
  parameter int         ID_CONT     = 12,
  parameter logic [7:0] ID_MFR      = 8'hef,
  parameter logic [7:0] ID_DENS     = 8'h14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  output logic [7:0]              tx_byte,
  output logic                    fl_req,
  output logic [1:0]              fl_op,
  output logic [8*ADDR_BYTES-1:0] fl_addr,
  output logic [8*PROG_BYTES-1:0] fl_data,
  input  logic                    fl_done,
  output logic                    reset_req,
  output logic                    shutdown
);
  localparam int          ADDR_W = 8 * ADDR_BYTES;
  localparam int          DATA_W = 8 * PROG_BYTES;
  localparam logic [7:0]  AB     = 8'(ADDR_BYTES);

  cmd_e              cmd_q;
  logic [7:0]        cnt_q;
  logic [ADDR_W-1:0] addr_q, ptr_q;
  logic [DATA_W-1:0] dbuf_q;
  logic [7:0]        tx_q;
  logic              wel_q, phase2_q, rreq_q, shut_q;

  logic              busy, fin, fin_erase, addr_ok, ended;
  logic              cmd_full, launch, go_shut;
  fop_e              start_op, fop_w;
  logic [ADDR_W-1:0] tbl_idx;
  logic [7:0]        tbl_resp, status;

  assign ended  = rreq_q | shut_q;
  assign status = {6'b0, wel_q, busy};

  // Response byte source for identity and parameter-table reads
  assign tbl_idx = (cmd_q == C_PTAB && cnt_q == AB) ? addr_q : ptr_q;

  boot_resp_table #(
    .IDX_W(ADDR_W), .ID_CONT(ID_CONT), .ID_MFR(ID_MFR),
    .ID_DENS(ID_DENS), .FLASH_BYTES(FLASH_BYTES)
  ) u_table (
    .use_ptab(cmd_q == C_PTAB), .idx(tbl_idx), .resp(tbl_resp)
  );

  boot_addr_check #(.ADDR_W(ADDR_W), .FLASH_BYTES(FLASH_BYTES)) u_range (
    .addr(addr_q), .in_range(addr_ok)
  );

  // Execution decision at chip-select release
  always_comb begin
    cmd_full = 1'b0;
    start_op = FOP_NONE;
    case (cmd_q)
      C_CHIP: begin cmd_full = 1'b1;          start_op = FOP_CHIP; end
      C_SECT: begin cmd_full = (cnt_q >= AB); start_op = FOP_SECT; end
      C_PROG: begin cmd_full = (cnt_q > AB);  start_op = FOP_PROG; end
      default: ;
    endcase
  end

  assign launch  = !sel && cmd_full && !ended && (addr_ok || cmd_q == C_CHIP);
  assign go_shut = !sel && cmd_full && !ended && !addr_ok && cmd_q != C_CHIP;

  boot_flash_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .start(launch), .start_op(start_op),
    .start_addr(cmd_q == C_CHIP ? '0 : addr_q), .start_data(dbuf_q),
    .fl_done(fl_done), .fl_req(busy), .fl_op(fop_w), .fl_addr(fl_addr),
    .fl_data(fl_data), .fin(fin), .fin_erase(fin_erase)
  );

  assign fl_req = busy;
  assign fl_op  = fop_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= C_OPC;
      cnt_q    <= '0;
      addr_q   <= '0;
      ptr_q    <= '0;
      dbuf_q   <= '1;
      tx_q     <= 8'hff;
      wel_q    <= 1'b0;
      phase2_q <= 1'b0;
      rreq_q   <= 1'b0;
      shut_q   <= 1'b0;
    end else begin
      if (!sel) begin
        cmd_q  <= C_OPC;
        cnt_q  <= '0;
        ptr_q  <= '0;
        dbuf_q <= '1;
        tx_q   <= 8'hff;
        if (go_shut) shut_q <= 1'b1;
      end else if (rx_valid) begin
        if (cmd_q == C_OPC) begin
          cnt_q <= '0;
          tx_q  <= 8'hff;
          cmd_q <= C_IGN;
          if (!ended) begin
            if (rx_byte == OPC_STATUS) begin
              cmd_q <= C_STAT;
              tx_q  <= status;
            end else if (rx_byte == OPC_RESET) begin
              rreq_q <= 1'b1;
            end else if (!busy) begin
              case (rx_byte)
                OPC_WREN:  wel_q <= 1'b1;
                OPC_WRDI:  wel_q <= 1'b0;
                OPC_IDENT: begin
                  cmd_q <= C_IDENT;
                  tx_q  <= tbl_resp;
                  ptr_q <= ADDR_W'(1);
                end
                OPC_PTAB:  cmd_q <= C_PTAB;
                OPC_PROG:  if (phase2_q && wel_q) cmd_q <= C_PROG;
                OPC_SECT:  if (wel_q) cmd_q <= C_SECT;
                OPC_CHIP:  if (wel_q) cmd_q <= C_CHIP;
                default: ;
              endcase
            end
          end
        end else begin
          if (cnt_q != '1) cnt_q <= cnt_q + 8'd1;
          case (cmd_q)
            C_STAT: tx_q <= status;
            C_IDENT: begin
              tx_q  <= tbl_resp;
              ptr_q <= ptr_q + ADDR_W'(1);
            end
            C_PTAB: begin
              if (cnt_q < AB) begin
                addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
              end else if (cnt_q == AB) begin
                tx_q  <= tbl_resp;
                ptr_q <= addr_q + ADDR_W'(1);
              end else begin
                tx_q  <= tbl_resp;
                ptr_q <= ptr_q + ADDR_W'(1);
              end
            end
            C_SECT: if (cnt_q < AB) addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
            C_PROG: begin
              if (cnt_q < AB) addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
              for (int i = 0; i < PROG_BYTES; i++)
                if (cnt_q == AB + 8'(i)) dbuf_q[i*8 +: 8] <= rx_byte;
            end
            default: ;
          endcase
        end
      end
      if (ended) tx_q <= 8'hff;
      if (fin) wel_q <= 1'b0;
      if (fin_erase) phase2_q <= 1'b1;
    end
  end

  assign tx_byte   = tx_q;
  assign reset_req = rreq_q;
  assign shutdown  = shut_q;

  // R6: nothing is driven while the frame is closed
  assert_idle_tx_R6: assert property (@(posedge clk) disable iff (rst)
    !sel |=> tx_byte == 8'hff);
  // R7: a program request only ever starts in the second phase
  assert_prog_phase_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_req) && fl_op == 2'd1 |-> phase2_q);
  // R8: WEL is gone after a finished request
  assert_wel_clear_R8: assert property (@(posedge clk) disable iff (rst)
    fl_req && fl_done |=> !wel_q);
  // R11: reset request is sticky and silences the output
  assert_rreq_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req);
  assert_ended_tx_R11: assert property (@(posedge clk) disable iff (rst)
    reset_req || shutdown |=> tx_byte == 8'hff);
  // R12: shutdown is sticky, and no addressed request leaves the flash range
  assert_shut_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> shutdown);
  assert_range_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_req) && fl_op != 2'd3 |-> 64'(fl_addr) < 64'(FLASH_BYTES));
  // R14: WEL cannot move while a request waits
  assert_busy_wel_R14: assert property (@(posedge clk) disable iff (rst)
    fl_req && !fl_done |=> $stable(wel_q));
endmodule

// File: tb/spi_boot_ctrl_bench.sv
`timescale 1ns/100ps
module spi_boot_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        fl_done = 1'b0;
  logic [7:0]  tx_byte;
  logic        fl_req, reset_req, shutdown;
  logic [1:0]  fl_op;
  logic [23:0] fl_addr;
  logic [31:0] fl_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_boot_ctrl u_spi_boot_ctrl (
    .clk(clk), .rst(rst), .sel(sel), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr),
    .fl_data(fl_data), .fl_done(fl_done), .reset_req(reset_req),
    .shutdown(shutdown)
  );

  // {opcode, reply after opcode, reply after one more byte}; first phase
  localparam logic [23:0] VEC [0:9] = '{
    24'h05_00_00,  // R2 idle status
    24'h06_ff_ff,  // R3 set latch
    24'h05_02_02,  // R3 latch visible
    24'h02_ff_ff,  // R7 program ignored in first phase
    24'h05_02_02,  // R7 latch untouched
    24'h04_ff_ff,  // R3 clear latch
    24'h05_00_00,  // R3 latch cleared
    24'h03_ff_ff,  // R6 read ignored
    24'h9f_7f_7f,  // R4 identity start
    24'h3b_ff_ff   // R6 unknown opcode
  };
  localparam logic [3:0] VTAG [0:9] = '{2, 3, 3, 7, 7, 3, 3, 6, 4, 6};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cs_on();
    @(negedge clk) sel = 1'b1;
  endtask

  task automatic rel();
    @(negedge clk) sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk) fl_done = 1'b1;
    @(negedge clk) fl_done = 1'b0;
  endtask

  task automatic one_cmd(input logic [7:0] op);
    cs_on(); send(op); rel();
  endtask

  task automatic status_is(input string tag, input logic [7:0] exp);
    cs_on(); send(8'h05); chk(tag, tx_byte, exp); rel();
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx", tx_byte, 8'hff);
    chk("R1 req", fl_req, 0);
    chk("R1 reset_req", reset_req, 0);
    chk("R1 shutdown", shutdown, 0);

    // Vector walk
    for (int i = 0; i < 10; i++) begin
      cs_on();
      send(VEC[i][23:16]);
      chk($sformatf("R%0d vec%0d first", VTAG[i], i), tx_byte, VEC[i][15:8]);
      send(8'h00);
      chk($sformatf("R%0d vec%0d second", VTAG[i], i), tx_byte, VEC[i][7:0]);
      rel();
      chk($sformatf("R%0d vec%0d no request", VTAG[i], i), fl_req, 0);
    end

    // R4 full identity
    cs_on(); send(8'h9f);
    for (int i = 0; i < 15; i++) begin
      chk($sformatf("R4 id byte %0d", i), tx_byte,
          i < 12 ? 8'h7f : (i == 12 ? 8'hef : (i == 13 ? 8'h14 : 8'hff)));
      send(8'h00);
    end
    rel();

    // R5 parameter table at 0 and at the density word
    cs_on(); send(8'h5a); send(8'h00); send(8'h00); send(8'h00); send(8'h00);
    chk("R5 sig0", tx_byte, 8'h53); send(8'h00);
    chk("R5 sig1", tx_byte, 8'h46); send(8'h00);
    chk("R5 sig2", tx_byte, 8'h44); send(8'h00);
    chk("R5 sig3", tx_byte, 8'h50);
    rel();
    cs_on(); send(8'h5a); send(8'h00); send(8'h00); send(8'h14); send(8'h00);
    chk("R5 dens0", tx_byte, 8'hff); send(8'h00);
    chk("R5 dens1", tx_byte, 8'hff); send(8'h00);
    chk("R5 dens2", tx_byte, 8'h7f); send(8'h00);
    chk("R5 dens3", tx_byte, 8'h00);
    rel();
    cs_on(); send(8'h5a); send(8'h00); send(8'h00); send(8'h11); send(8'h00);
    chk("R5 erase opcode byte", tx_byte, 8'h20);
    rel();
    cs_on(); send(8'h5a); send(8'h00); send(8'h00); send(8'h34); send(8'h00);
    chk("R5 past table", tx_byte, 8'hff);
    rel();

    // R6 read with address in the first phase
    cs_on(); send(8'h03); send(8'h00); send(8'h03); send(8'h34);
    for (int i = 0; i < 4; i++) begin
      send(8'h00);
      chk($sformatf("R6 read data %0d", i), tx_byte, 8'hff);
    end
    rel();

    // R10 erase without latch
    cs_on(); send(8'h20); send(8'h00); send(8'h10); send(8'h00); rel();
    repeat (3) @(negedge clk);
    chk("R10 no request", fl_req, 0);

    // R13 frame cut short
    one_cmd(8'h06);
    cs_on(); send(8'h20); send(8'h00); send(8'h10); rel();
    repeat (3) @(negedge clk);
    chk("R13 aborted", fl_req, 0);
    status_is("R13 latch kept", 8'h02);

    // R8 first-phase sector erase
    cs_on(); send(8'h20); send(8'h00); send(8'h10); send(8'h00); rel();
    chk("R8 req", fl_req, 1);
    chk("R8 op", fl_op, 2'd2);
    chk("R8 addr", fl_addr, 24'h001000);
    status_is("R14 busy status", 8'h03);
    cs_on(); send(8'h9f); chk("R14 id while busy", tx_byte, 8'hff); rel();
    one_cmd(8'h04);
    status_is("R14 clear ignored while busy", 8'h03);
    done_pulse();
    chk("R8 released", fl_req, 0);
    status_is("R8 latch cleared", 8'h00);

    // R6 read still ignored in the second phase
    cs_on(); send(8'h03); send(8'h00); send(8'h00); send(8'h00); send(8'h00);
    chk("R6 second phase read", tx_byte, 8'hff);
    rel();

    // R9 program at last valid address (R12 boundary)
    one_cmd(8'h06);
    cs_on(); send(8'h02); send(8'h0f); send(8'hff); send(8'hff);
    send(8'haa); send(8'hbb); rel();
    chk("R9 req", fl_req, 1);
    chk("R9 op", fl_op, 2'd1);
    chk("R12 last address accepted", fl_addr, 24'h0fffff);
    chk("R9 data", fl_data, 32'hffffbbaa);
    chk("R12 no shutdown at boundary", shutdown, 0);
    done_pulse();
    status_is("R9 latch cleared", 8'h00);

    // R8 chip erase in the second phase
    one_cmd(8'h06);
    one_cmd(8'hc7);
    chk("R8 chip req", fl_req, 1);
    chk("R8 chip op", fl_op, 2'd3);
    done_pulse();

    // R12 first out-of-range address
    one_cmd(8'h06);
    cs_on(); send(8'h20); send(8'h10); send(8'h00); send(8'h00); rel();
    chk("R12 shutdown", shutdown, 1);
    chk("R12 no request", fl_req, 0);
    status_is("R12 ignored after shutdown", 8'hff);

    // R1 again, then R11
    do_reset();
    chk("R1 shutdown cleared", shutdown, 0);
    status_is("R1 status after reset", 8'h00);
    one_cmd(8'h06);
    cs_on(); send(8'h02); send(8'h00); send(8'h00); send(8'h00); send(8'h11); rel();
    chk("R7 program after reset", fl_req, 0);
    cs_on(); send(8'h99);
    chk("R11 reset_req", reset_req, 1);
    rel();
    status_is("R11 status ignored", 8'hff);
    chk("R11 reset_req held", reset_req, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule